// File: doc/BRIEF.md
# Two-Master Priority Bus Arbiter

This block decides which of two masters drives a shared on-chip bus: a processor and a transfer engine that moves data on its own. The transfer engine always wins a contest, but it can only take the bus from the processor at a clean point. That point is the end of a bus cycle that is not part of a split access, for example the first half of a longword done as two word cycles. The one exception is when the processor is asleep. Then the transfer engine gets the bus without waiting for a cycle boundary.

The processor is the parked owner. It holds its grant after reset and whenever the transfer engine is not asking for the bus. Once the transfer engine holds the bus, it keeps it until it drops its request. The bus then goes back to the processor at the next unlocked cycle end. Every change of owner passes through one clock in which neither grant is high. `owner_o` names the master that the bus is assigned to, including during that gap.

Top module: `bus_arb2`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, cpu_gnt_o=1, xfer_gnt_o=0 and owner_o=0.
- R2: cpu_gnt_o and xfer_gnt_o are never high in the same cycle.
- R3: While the processor holds the bus, the arbiter starts a handover at a clock edge that samples xfer_req_i=1, cycle_end_i=1 and lock_i=0. After that edge both grants are low. After the following edge, xfer_gnt_o=1.
- R4: While the processor holds the bus and cpu_sleep_i=0, an edge that samples cycle_end_i=1 together with lock_i=1 leaves cpu_gnt_o high.
- R5: While the processor holds the bus and cpu_sleep_i=0, an edge that samples cycle_end_i=0 leaves cpu_gnt_o high, whatever xfer_req_i is.
- R6: While the processor holds the bus, an edge that samples cpu_sleep_i=1 and xfer_req_i=1 starts the handover, whatever cycle_end_i and lock_i are.
- R7: While the transfer engine holds the bus and xfer_req_i=1, it keeps xfer_gnt_o high, whatever cpu_req_i, cycle_end_i and lock_i are.
- R8: While the transfer engine holds the bus, an edge that samples xfer_req_i=0, cycle_end_i=1 and lock_i=0 drops xfer_gnt_o. cpu_gnt_o rises one edge later. Without such an edge, the transfer engine keeps the bus.
- R9: owner_o=1 from the edge that starts a handover to the transfer engine until the edge that starts the return. In all other cycles owner_o=0.
- R10: A cycle with both grants low is always followed by a cycle with exactly one grant high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor bus request |
| xfer_req_i | input | 1 | Transfer engine bus request, held for its whole operation |
| cycle_end_i | input | 1 | Current bus cycle finishes at this edge |
| lock_i | input | 1 | Current cycle is a non-final part of a split access |
| cpu_sleep_i | input | 1 | Processor is in sleep mode |
| cpu_gnt_o | output | 1 | Processor grant |
| xfer_gnt_o | output | 1 | Transfer engine grant |
| owner_o | output | 1 | Assigned owner: 0 processor, 1 transfer engine |

## Verification
The assertions assume that cycle_end_i, lock_i and cpu_sleep_i are valid at every edge, and that a request counts only at the edge where it is sampled. They do not assume that the transfer engine keeps its request up until it is granted. The stimulus changes inputs only on the falling edge, so they are stable at each rising edge. Directed phases hold lock high across cycle ends, keep sleep high with cycle_end low, and assert the processor request during transfer ownership. A long random phase then draws the inputs with separate biases, so that locked cycle ends, sleep handovers and requests withdrawn in the gap cycle all occur.

// File: rtl/bus_arb2_pkg.sv
package bus_arb2_pkg;
  typedef enum logic [1:0] {
    ST_CPU    = 2'b00,
    ST_TO_XF  = 2'b01,
    ST_XF     = 2'b11,
    ST_TO_CPU = 2'b10
  } arb_state_e;
endpackage

// File: rtl/bus_arb2_bnd.sv
module bus_arb2_bnd (
  input  logic xfer_req_i,
  input  logic cycle_end_i,
  input  logic lock_i,
  input  logic cpu_sleep_i,
  output logic take_o,
  output logic give_o
);
  logic safe_pt;
  // lock masks the cycle end of a non-final split component
  assign safe_pt = cycle_end_i & ~lock_i;
  assign take_o  = xfer_req_i & (cpu_sleep_i | safe_pt);
  assign give_o  = ~xfer_req_i & safe_pt;
endmodule

// File: rtl/bus_arb2_fsm.sv
module bus_arb2_fsm
  import bus_arb2_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  input  logic cpu_req_i,
  input  logic xfer_req_i,
  input  logic cycle_end_i,
  input  logic lock_i,
  input  logic cpu_sleep_i,
  output logic cpu_gnt_o,
  output logic xfer_gnt_o,
  output logic owner_o
);
  arb_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CPU:    if (take_i) st_d = ST_TO_XF;
      ST_TO_XF:  st_d = ST_XF;
      ST_XF:     if (give_i) st_d = ST_TO_CPU;
      ST_TO_CPU: st_d = ST_CPU;
      default:   st_d = ST_CPU;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_CPU;
    else         st_q <= st_d;
  end

  assign cpu_gnt_o  = (st_q == ST_CPU);
  assign xfer_gnt_o = (st_q == ST_XF);
  assign owner_o    = st_q[0];

  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_gnt_o && xfer_gnt_o));
  assert_no_hop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o && !cycle_end_i && !cpu_sleep_i) |=> cpu_gnt_o);
  assert_lock_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o && lock_i && !cpu_sleep_i) |=> cpu_gnt_o);
  assert_sleep_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o && xfer_req_i && cpu_sleep_i) |=> (!cpu_gnt_o && !xfer_gnt_o && owner_o));
  assert_xf_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_gnt_o && xfer_req_i && cpu_req_i) |=> xfer_gnt_o);
  assert_gap_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_gnt_o && !xfer_gnt_o) |=> (cpu_gnt_o || xfer_gnt_o));
  assert_gap_dest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_gnt_o && !xfer_gnt_o) |=> (xfer_gnt_o == $past(owner_o)));
endmodule

// File: rtl/bus_arb2.sv
module bus_arb2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic xfer_req_i,
  input  logic cycle_end_i,
  input  logic lock_i,
  input  logic cpu_sleep_i,
  output logic cpu_gnt_o,
  output logic xfer_gnt_o,
  output logic owner_o
);
  logic take, give;

  bus_arb2_bnd u_bnd (
    .xfer_req_i (xfer_req_i),
    .cycle_end_i(cycle_end_i),
    .lock_i     (lock_i),
    .cpu_sleep_i(cpu_sleep_i),
    .take_o     (take),
    .give_o     (give)
  );

  bus_arb2_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .give_i     (give),
    .cpu_req_i  (cpu_req_i),
    .xfer_req_i (xfer_req_i),
    .cycle_end_i(cycle_end_i),
    .lock_i     (lock_i),
    .cpu_sleep_i(cpu_sleep_i),
    .cpu_gnt_o  (cpu_gnt_o),
    .xfer_gnt_o (xfer_gnt_o),
    .owner_o    (owner_o)
  );
endmodule

// File: tb/sim_bus_arb2.sv
`timescale 1ns/1ps
module sim_bus_arb2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic creq = 1'b0, xreq = 1'b0, ce = 1'b0, lk = 1'b0, slp = 1'b0;
  logic cg, xg, own;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  bus_arb2 u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(creq), .xfer_req_i(xreq),
    .cycle_end_i(ce), .lock_i(lk), .cpu_sleep_i(slp),
    .cpu_gnt_o(cg), .xfer_gnt_o(xg), .owner_o(own)
  );

  // reference: owner index and remaining gap cycles
  int m_own = 0, m_gap = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own <= 0; m_gap <= 0;
    end else if (m_gap > 0) begin
      m_gap <= m_gap - 1;
    end else if (m_own == 0 && xreq && (slp || (ce && !lk))) begin
      m_own <= 1; m_gap <= 1;
    end else if (m_own == 1 && !xreq && ce && !lk) begin
      m_own <= 0; m_gap <= 1;
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ecg, exg;
    ecg = (m_gap == 0 && m_own == 0) ? 1 : 0;
    exg = (m_gap == 0 && m_own == 1) ? 1 : 0;
    chk({cg, xg} == {ecg[0], exg[0]}, tag, {cg, xg}, {ecg[0], exg[0]});
    chk(own == m_own[0], "R9", own, m_own);
    chk(!(cg && xg), "R2", {cg, xg}, 0);
  endtask

  task automatic step(input logic c, input logic x, input logic e, input logic l, input logic s);
    @(negedge clk);
    compare();
    creq = c; xreq = x; ce = e; lk = l; slp = s;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    compare();
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    tag = "R5";
    repeat (3) step(1, 1, 0, 0, 0);
    tag = "R4";
    repeat (3) step(1, 1, 1, 1, 0);
    tag = "R3";
    step(1, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    chk(xg == 1'b1, "R3", xg, 1);
    tag = "R7";
    for (int i = 0; i < 8; i++) step(1, 1, 1'(i & 1), 1'(i >> 1 & 1), 0);
    tag = "R8";
    step(1, 0, 0, 0, 0);
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(cg == 1'b1, "R8", cg, 1);
    tag = "R6";
    step(0, 1, 0, 1, 1);
    step(0, 1, 0, 1, 1);
    step(0, 1, 0, 0, 0);
    chk(xg == 1'b1, "R6", xg, 1);
    tag = "R10";
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    tag = "R2";
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 7) == 0));
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule